// File: doc/BRIEF.md
# Watchdog Timer with Pretimeout Counter

This peripheral watches over system software through two 32-bit down-counters that software reaches over a simple register bus. Software loads the main watchdog counter with a timeout in ticks and must rewrite it before it runs out. A second counter runs alongside it and is loaded with a shorter count, the timeout less a pretimeout margin. That counter runs out first and warns software through an interrupt before the watchdog itself expires.

Both counters step on a common tick. The tick comes either from an external reference-tick input or from the system clock divided by a power of two. The divide ratio is held in a field of the control register.

Each expiry sets a sticky status flag and pulses an interrupt for one clock. A system reset request is raised after a watchdog expiry, but only while three conditions all hold: the watchdog is enabled, the reset-output enable bit is set, and the reset-mask bit is clear.

Top module: `wdog_pretimer`

## Requirements
- R1: After reset every register reads as zero, and `pre_irq`, `exp_irq`, `rst_req` and `bus_rdata` are low.
- R2: A write at offset 0x34 loads the watchdog counter. A read at that offset returns the remaining count one clock after the read is presented. Rewriting the counter reloads it, which is how software pings the watchdog.
- R3: An enabled counter drops by exactly one on each tick. Clearing its enable bit (watchdog: control bit 8; pretimeout: control bit 2) freezes the count. Setting the bit again resumes counting from the frozen value.
- R4: Control bit 10 set makes the tick equal to `ref_tick`. Control bit 10 clear makes the tick come from the system clock divided by 2^k, where k is the field at control bits 16 and up. Every control write restarts the divider, so with the divider selected the first decrement lands 2^k clocks after the write.
- R5: The pretimeout counter sits at offset 0x1c. When it steps from 1 to 0 it pulses `pre_irq` for one clock, and status bit 8 is set on the following clock.
- R6: When the watchdog counter steps from 1 to 0 it pulses `exp_irq` for one clock, and status bit 31 is set on the following clock.
- R7: Status bits 31 and 8 stay set until software writes the status register (offset 0x04) with that bit at 0. Writing a 1 to a bit leaves it unchanged.
- R8: `rst_req` goes high one clock after all of the following hold: status bit 31 is set, control bit 8 is set, bit 8 of the reset-enable register (offset 0x40) is set, and bit 10 of the reset-mask register (offset 0x44) is clear. It drops one clock after any of these stops holding.
- R9: A counter at zero stays at zero and raises no further interrupt pulses. Loading zero into a running counter produces no expiry.
- R10: The full 32-bit count is supported. 0xFFFFFFFF loads and reads back exactly, and one tick later the counter holds 0xFFFFFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one clock per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered, valid one clock after the read |
| ref_tick | input | 1 | Reference tick enable, one clock wide per tick |
| pre_irq | output | 1 | Pretimeout interrupt pulse |
| exp_irq | output | 1 | Watchdog expiry interrupt pulse |
| rst_req | output | 1 | System reset request level |

## Verification
The bench builds the block with `RATIO_W = 3`, so the divide field spans 0 to 7. A full sweep of every ratio against timeouts of 1 to 3 ticks then stays within a few hundred clocks per case. Each measured delay from the control write to `exp_irq` is compared against timeout·2^k. Counting itself is tested with the reference tick, which the bench drives directly. This lets it place every decrement, freeze, reload and expiry on a known clock edge. The same control covers the gating of `rst_req` by the enable and mask bits.

// File: rtl/wdp_pkg.sv
package wdp_pkg;
  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_STAT  = 8'h04;
  localparam logic [7:0] OFF_PRE   = 8'h1c;
  localparam logic [7:0] OFF_WDOG  = 8'h34;
  localparam logic [7:0] OFF_RSTEN = 8'h40;
  localparam logic [7:0] OFF_RMASK = 8'h44;

  localparam int BIT_PRE_EN    = 2;
  localparam int BIT_WD_EN     = 8;
  localparam int BIT_REF_SEL   = 10;
  localparam int RATIO_LSB     = 16;
  localparam int BIT_STAT_PRE  = 8;
  localparam int BIT_STAT_EXP  = 31;
  localparam int BIT_RST_EN    = 8;
  localparam int BIT_RST_MASK  = 10;
endpackage

// File: rtl/wdp_tick_gen.sv
module wdp_tick_gen #(
  parameter int RATIO_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic               ref_sel,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               ref_tick,
  output logic               tick
);
  localparam int PS_W = (1 << RATIO_W) - 1;

  logic [PS_W-1:0] pcnt;
  logic [PS_W-1:0] mask;
  logic            div_tick;

  always_comb begin
    mask     = ~({PS_W{1'b1}} << ratio);
    div_tick = ((pcnt & mask) == mask);
    tick     = ref_sel ? ref_tick : div_tick;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) pcnt <= '0;
    else                pcnt <= pcnt + 1'b1;
  end

  // R4: the divider restarts from zero after a control write
  p_restart_r4: assert property (@(posedge clk) disable iff (rst)
    restart |=> (pcnt == '0));
endmodule

// File: rtl/wdp_down_counter.sv
module wdp_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      hit   <= 1'b0;
    end else begin
      hit <= 1'b0;
      if (load) begin
        count <= load_val;
      end else if (run && tick && (count != '0)) begin
        count <= count - 1'b1;
        if (count == CNT_W'(1)) hit <= 1'b1;
      end
    end
  end

  p_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(count));

  p_single_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && count != '0) |=> (count == $past(count) || count == $past(count) - 1'b1));

  p_stay_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (!load && count == '0) |=> (count == '0 && !hit));
endmodule

// File: rtl/wdog_pretimer.sv
module wdog_pretimer #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int RATIO_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ref_tick,
  output logic              pre_irq,
  output logic              exp_irq,
  output logic              rst_req
);
  import wdp_pkg::*;

  logic [DATA_W-1:0] ctrl_q;
  logic              rst_en_q;
  logic              rst_mask_q;
  logic              stat_exp;
  logic              stat_pre;
  logic [DATA_W-1:0] wd_count;
  logic [DATA_W-1:0] pre_count;
  logic              wd_hit;
  logic              pre_hit;
  logic              tick;
  logic [DATA_W-1:0] rd_mux;

  logic wr_ctrl, wr_stat, wr_pre, wr_wdog, wr_rsten, wr_rmask, rd_en;

  always_comb begin
    wr_ctrl  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
    wr_stat  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_STAT));
    wr_pre   = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_PRE));
    wr_wdog  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_WDOG));
    wr_rsten = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_RSTEN));
    wr_rmask = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_RMASK));
    rd_en    = bus_sel && !bus_wr;
  end

  wdp_tick_gen #(.RATIO_W(RATIO_W)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .restart  (wr_ctrl),
    .ref_sel  (ctrl_q[BIT_REF_SEL]),
    .ratio    (ctrl_q[RATIO_LSB +: RATIO_W]),
    .ref_tick (ref_tick),
    .tick     (tick)
  );

  wdp_down_counter #(.CNT_W(DATA_W)) u_wd (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_wdog),
    .load_val (bus_wdata),
    .run      (ctrl_q[BIT_WD_EN]),
    .tick     (tick),
    .count    (wd_count),
    .hit      (wd_hit)
  );

  wdp_down_counter #(.CNT_W(DATA_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_pre),
    .load_val (bus_wdata),
    .run      (ctrl_q[BIT_PRE_EN]),
    .tick     (tick),
    .count    (pre_count),
    .hit      (pre_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      rst_en_q   <= 1'b0;
      rst_mask_q <= 1'b0;
      stat_exp   <= 1'b0;
      stat_pre   <= 1'b0;
      rst_req    <= 1'b0;
    end else begin
      if (wr_ctrl)  ctrl_q     <= bus_wdata;
      if (wr_rsten) rst_en_q   <= bus_wdata[BIT_RST_EN];
      if (wr_rmask) rst_mask_q <= bus_wdata[BIT_RST_MASK];
      if (wd_hit)       stat_exp <= 1'b1;
      else if (wr_stat) stat_exp <= stat_exp & bus_wdata[BIT_STAT_EXP];
      if (pre_hit)      stat_pre <= 1'b1;
      else if (wr_stat) stat_pre <= stat_pre & bus_wdata[BIT_STAT_PRE];
      rst_req <= stat_exp && ctrl_q[BIT_WD_EN] && rst_en_q && !rst_mask_q;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(OFF_CTRL):  rd_mux = ctrl_q;
      ADDR_W'(OFF_STAT): begin
        rd_mux[BIT_STAT_EXP] = stat_exp;
        rd_mux[BIT_STAT_PRE] = stat_pre;
      end
      ADDR_W'(OFF_PRE):   rd_mux = pre_count;
      ADDR_W'(OFF_WDOG):  rd_mux = wd_count;
      ADDR_W'(OFF_RSTEN): rd_mux[BIT_RST_EN] = rst_en_q;
      ADDR_W'(OFF_RMASK): rd_mux[BIT_RST_MASK] = rst_mask_q;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end

  assign exp_irq = wd_hit;
  assign pre_irq = pre_hit;

  p_exp_flag_r6: assert property (@(posedge clk) disable iff (rst)
    exp_irq |=> stat_exp);

  p_pre_flag_r5: assert property (@(posedge clk) disable iff (rst)
    pre_irq |=> stat_pre);

  p_exp_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_exp && !(wr_stat && !bus_wdata[BIT_STAT_EXP])) |=> stat_exp);

  p_mask_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    rst_mask_q |=> !rst_req);

  p_needs_flag_r8: assert property (@(posedge clk) disable iff (rst)
    !stat_exp |=> !rst_req);
endmodule

// File: tb/sim_wdog_pretimer.sv
`timescale 1ns/1ps
module sim_wdog_pretimer;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int RW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          ref_tick = 1'b0;
  logic          pre_irq, exp_irq, rst_req;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdog_pretimer #(.DATA_W(DW), .ADDR_W(AW), .RATIO_W(RW)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ref_tick(ref_tick), .pre_irq(pre_irq), .exp_irq(exp_irq), .rst_req(rst_req)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [DW-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse();
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
  endtask

  function automatic logic [DW-1:0] cw(input bit wd, input bit pre, input bit rs, input int ratio);
    return (DW'(wd) << 8) | (DW'(pre) << 2) | (DW'(rs) << 10) | (DW'(ratio) << 16);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    int cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 pre_irq", DW'(pre_irq), 0);
    check("R1 exp_irq", DW'(exp_irq), 0);
    check("R1 rst_req", DW'(rst_req), 0);
    check("R1 rdata", bus_rdata, 0);
    rd(8'h00, d); check("R1 ctrl", d, 0);
    rd(8'h04, d); check("R1 status", d, 0);
    rd(8'h1c, d); check("R1 pre count", d, 0);
    rd(8'h34, d); check("R1 wd count", d, 0);
    rd(8'h40, d); check("R1 rst enable", d, 0);
    rd(8'h44, d); check("R1 rst mask", d, 0);

    // R2 load, read, ping
    wr(8'h34, 10);
    rd(8'h34, d); check("R2 load readback", d, 10);
    wr(8'h00, cw(1, 0, 1, 0));
    pulse(); pulse();
    rd(8'h34, d); check("R2 count after 2 ticks", d, 8);
    wr(8'h34, 10);
    rd(8'h34, d); check("R2 ping reload", d, 10);

    // R3 freeze and resume
    pulse(); pulse(); pulse();
    rd(8'h34, d); check("R3 three ticks", d, 7);
    wr(8'h00, cw(0, 0, 1, 0));
    pulse(); pulse();
    rd(8'h34, d); check("R3 frozen", d, 7);
    wr(8'h00, cw(1, 0, 1, 0));
    pulse();
    rd(8'h34, d); check("R3 resumed", d, 6);

    // R4 reference source ignores system clock when ref_tick idle
    repeat (20) @(negedge clk);
    rd(8'h34, d); check("R4 no ref tick no step", d, 6);

    // R10 full-width count
    wr(8'h34, 32'hFFFF_FFFF);
    rd(8'h34, d); check("R10 max load", d, 32'hFFFF_FFFF);
    pulse();
    rd(8'h34, d); check("R10 max minus one", d, 32'hFFFF_FFFE);

    // R5 / R6 pretimeout before expiry
    wr(8'h00, 0);
    wr(8'h34, 5);
    wr(8'h1c, 2);
    wr(8'h00, cw(1, 1, 1, 0));
    pulse();
    check("R5 no early pre_irq", DW'(pre_irq), 0);
    pulse();
    check("R5 pre_irq pulse", DW'(pre_irq), 1);
    check("R6 no exp yet", DW'(exp_irq), 0);
    @(negedge clk);
    check("R5 pre_irq one clock", DW'(pre_irq), 0);
    rd(8'h04, d); check("R5 status pre flag", d, 32'h0000_0100);
    pulse(); pulse();
    check("R6 no exp at 1", DW'(exp_irq), 0);
    pulse();
    check("R6 exp_irq pulse", DW'(exp_irq), 1);
    @(negedge clk);
    check("R6 exp_irq one clock", DW'(exp_irq), 0);
    rd(8'h04, d); check("R6 status both flags", d, 32'h8000_0100);
    check("R8 no reset without enable", DW'(rst_req), 0);

    // R9 stays at zero
    pulse(); pulse();
    check("R9 no repeat irq", DW'(exp_irq), 0);
    rd(8'h34, d); check("R9 count stays zero", d, 0);
    rd(8'h1c, d); check("R9 pre stays zero", d, 0);

    // R7 sticky flags
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); check("R7 write ones keeps", d, 32'h8000_0100);
    wr(8'h04, 32'h0000_0100);
    rd(8'h04, d); check("R7 clear exp only", d, 32'h0000_0100);
    wr(8'h04, 0);
    rd(8'h04, d); check("R7 clear all", d, 0);

    // R9 zero load does not expire
    wr(8'h34, 0);
    pulse();
    check("R9 zero load no irq", DW'(exp_irq), 0);
    @(negedge clk);
    rd(8'h04, d); check("R9 zero load no flag", d, 0);

    // R8 reset gating
    wr(8'h40, 32'h0000_0100);
    rd(8'h40, d); check("R8 rst enable readback", d, 32'h0000_0100);
    wr(8'h34, 2);
    pulse(); pulse();
    check("R8 expiry pulse", DW'(exp_irq), 1);
    @(negedge clk);
    check("R8 not before flag", DW'(rst_req), 0);
    @(negedge clk);
    check("R8 reset raised", DW'(rst_req), 1);
    wr(8'h44, 32'h0000_0400);
    @(negedge clk);
    check("R8 mask blocks", DW'(rst_req), 0);
    rd(8'h44, d); check("R8 mask readback", d, 32'h0000_0400);
    wr(8'h44, 0);
    @(negedge clk);
    check("R8 unmask raises", DW'(rst_req), 1);
    wr(8'h00, cw(0, 0, 1, 0));
    @(negedge clk);
    check("R8 disable drops", DW'(rst_req), 0);
    wr(8'h00, cw(1, 0, 1, 0));
    @(negedge clk);
    check("R8 re-enable raises", DW'(rst_req), 1);
    wr(8'h04, 0);
    @(negedge clk);
    check("R8 flag clear drops", DW'(rst_req), 0);
    wr(8'h40, 0);

    // R4 divider sweep
    for (int r = 0; r < (1 << RW); r++) begin
      for (int n = 1; n <= 3; n++) begin
        wr(8'h00, 0);
        wr(8'h04, 0);
        wr(8'h34, DW'(n));
        wr(8'h00, cw(1, 0, 0, r));
        cnt = 0;
        while (exp_irq !== 1'b1 && cnt < 4000) begin
          @(negedge clk);
          cnt++;
        end
        check($sformatf("R4 divider ratio %0d count %0d", r, n), DW'(cnt), DW'(n << r));
      end
    end
    wr(8'h00, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule